// File: doc/BRIEF.md
# Double-Buffered Photon Hit Counter

This block counts the hit pulses that a pixel's discriminator produces during one exposure frame. Each pulse lasts one clock cycle. A frame-latch strobe ends the frame. On that edge the running count moves into a shadow register and the live counter returns to zero. Counting for the next frame starts on the following cycle, while the stored value is read out at leisure.

The stored value comes out one 4-bit nibble at a time, picked by a nibble select. The counting depth can be 4, 8 or 12 bits. A deeper count gives more dynamic range. A shallower count needs fewer nibbles to read out, so the readout is faster. The counter saturates at the full scale of the selected depth and never wraps.

A new depth select value is taken only at a frame-latch strobe. A depth change therefore never breaks the count of a frame that is in progress.

Top module: `pixcnt_top`

## Requirements
- R1: With no strobe present, the live count goes up by exactly one on each rising edge where both `countEn` and `hitIn` are 1. On any edge where either of them is 0, the count holds.
- R2: The live count saturates at 2^N-1, where N is the active depth. Further hits leave it unchanged. `depthSel` codes map as follows: 0 = 4 bits, 1 = 8 bits, 2 = 12 bits, 3 = 12 bits.
- R3: On a rising edge with `latchStrobe` = 1, the shadow register takes the live count and the live count clears, both on that same edge. A hit present on that edge is counted in neither frame.
- R4: The shadow value stays the same on every edge without `latchStrobe`, whatever hits arrive in the meantime.
- R5: `depthSel` is sampled only on a `latchStrobe` edge. A change in the middle of a frame has no effect on that frame. After reset the active depth is 12 bits.
- R6: `nibbleOut` is a combinational function of `nibbleSel`. Select s (0..2) gives shadow bits [4s+3:4s], and select 3 gives 0.
- R7: Nibbles above the depth of the frame held in the shadow register read as 0.
- R8: After reset, the live count and the shadow value are 0, so every nibble reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hitIn | input | 1 | Single-cycle hit pulse from the discriminator |
| countEn | input | 1 | Enables counting of hits |
| latchStrobe | input | 1 | Ends the frame: store the count, clear it, sample the depth |
| depthSel | input | 2 | Depth code for the next frame (0: 4, 1: 8, 2/3: 12 bits) |
| nibbleSel | input | 2 | Picks the stored nibble to read out |
| nibbleOut | output | 4 | Selected nibble of the stored count |

## Verification
The assertions run on every cycle. They check the local stepping rules: the live count changes by at most one and never wraps, it holds when no hit is enabled, the strobe clears the live count and moves it into the shadow register, the shadow value holds between strobes, and the nibble mux returns the low nibble for select 0 and zero for the unused select. Some properties need the full history of a frame, and only the bench scenarios can show them. These are saturation at the exact full scale of each depth, the depth in force after reset, the fact that a depth change in mid-frame is ignored, the dropped hit on the strobe edge, and the zeroed nibbles above a shallow depth.

// File: rtl/pixcnt_pkg.sv
package pixcnt_pkg;

  localparam int DEF_NIBBLE_W    = 4;
  localparam int DEF_NUM_NIBBLES = 3;
  localparam int DEF_SEL_W       = 2;

  // Strobes from control to datapath, produced once per cycle.
  typedef struct packed {
    logic latch;   // end of frame: move live count to shadow and clear it
    logic incr;    // count one qualified hit
  } strobe_t;

endpackage

// File: rtl/pixcnt_ctrl.sv
module pixcnt_ctrl
  import pixcnt_pkg::*;
#(
  parameter int NUM_NIBBLES = DEF_NUM_NIBBLES,
  parameter int SEL_W       = DEF_SEL_W,
  parameter int NIB_CNT_W   = $clog2(NUM_NIBBLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hitIn,
  input  logic                 countEn,
  input  logic                 latchStrobe,
  input  logic [SEL_W-1:0]     depthSel,
  input  logic                 atLimit,
  output strobe_t              strobes,
  output logic [NIB_CNT_W-1:0] liveNibbles,
  output logic [NIB_CNT_W-1:0] storedNibbles
);

  // Depth code -> number of active nibbles; codes past the top clamp to full depth.
  function automatic logic [NIB_CNT_W-1:0] decodeDepth(input logic [SEL_W-1:0] sel);
    if (int'(sel) >= NUM_NIBBLES) return NIB_CNT_W'(NUM_NIBBLES);
    else                          return NIB_CNT_W'(int'(sel) + 1);
  endfunction

  // Depth of the running frame; only updated when a frame closes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveNibbles   <= NIB_CNT_W'(NUM_NIBBLES);
      storedNibbles <= NIB_CNT_W'(NUM_NIBBLES);
    end else if (latchStrobe) begin
      liveNibbles   <= decodeDepth(depthSel);
      storedNibbles <= liveNibbles;
    end
  end

  always_comb begin
    strobes.latch = latchStrobe;
    // Hits coinciding with the frame boundary fall in the dead slot.
    strobes.incr  = countEn & hitIn & ~latchStrobe & ~atLimit;
  end

endmodule

// File: rtl/pixcnt_datapath.sv
module pixcnt_datapath
  import pixcnt_pkg::*;
#(
  parameter int NIBBLE_W    = DEF_NIBBLE_W,
  parameter int NUM_NIBBLES = DEF_NUM_NIBBLES,
  parameter int NIB_CNT_W   = $clog2(NUM_NIBBLES + 1),
  parameter int NIB_SEL_W   = (NUM_NIBBLES > 1) ? $clog2(NUM_NIBBLES) : 1,
  parameter int CNT_W       = NIBBLE_W * NUM_NIBBLES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [NIB_CNT_W-1:0] liveNibbles,
  input  logic [NIB_CNT_W-1:0] storedNibbles,
  input  logic [NIB_SEL_W-1:0] nibbleSel,
  output logic                 atLimit,
  output logic [CNT_W-1:0]     liveCnt,
  output logic [CNT_W-1:0]     shadowCnt,
  output logic [NIBBLE_W-1:0]  nibbleOut
);

  logic [CNT_W-1:0]    limitMask;
  logic [NIBBLE_W-1:0] nibbleArr [NUM_NIBBLES];

  // Per-nibble full-scale mask for the running frame and masked readout of the stored one.
  for (genvar i = 0; i < NUM_NIBBLES; i++) begin : g_nib
    assign limitMask[i*NIBBLE_W +: NIBBLE_W] =
      (NIB_CNT_W'(i) < liveNibbles) ? {NIBBLE_W{1'b1}} : {NIBBLE_W{1'b0}};
    assign nibbleArr[i] =
      (NIB_CNT_W'(i) < storedNibbles) ? shadowCnt[i*NIBBLE_W +: NIBBLE_W] : {NIBBLE_W{1'b0}};
  end

  assign atLimit = (liveCnt == limitMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              liveCnt <= '0;
    else if (strobes.latch) liveCnt <= '0;
    else if (strobes.incr)  liveCnt <= liveCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shadowCnt <= '0;
    else if (strobes.latch) shadowCnt <= liveCnt;
  end

  always_comb begin
    nibbleOut = '0;
    for (int s = 0; s < NUM_NIBBLES; s++) begin
      if (nibbleSel == NIB_SEL_W'(s)) nibbleOut = nibbleArr[s];
    end
  end

endmodule

// File: rtl/pixcnt_top.sv
module pixcnt_top
  import pixcnt_pkg::*;
#(
  parameter  int NIBBLE_W    = DEF_NIBBLE_W,
  parameter  int NUM_NIBBLES = DEF_NUM_NIBBLES,
  parameter  int SEL_W       = DEF_SEL_W,
  localparam int NIB_SEL_W   = (NUM_NIBBLES > 1) ? $clog2(NUM_NIBBLES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hitIn,
  input  logic                 countEn,
  input  logic                 latchStrobe,
  input  logic [SEL_W-1:0]     depthSel,
  input  logic [NIB_SEL_W-1:0] nibbleSel,
  output logic [NIBBLE_W-1:0]  nibbleOut
);

  localparam int CNT_W     = NIBBLE_W * NUM_NIBBLES;
  localparam int NIB_CNT_W = $clog2(NUM_NIBBLES + 1);

  strobe_t              strobes;
  logic                 atLimit;
  logic [NIB_CNT_W-1:0] liveNibbles;
  logic [NIB_CNT_W-1:0] storedNibbles;
  logic [CNT_W-1:0]     liveCnt;
  logic [CNT_W-1:0]     shadowCnt;

  pixcnt_ctrl #(
    .NUM_NIBBLES (NUM_NIBBLES),
    .SEL_W       (SEL_W),
    .NIB_CNT_W   (NIB_CNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hitIn         (hitIn),
    .countEn       (countEn),
    .latchStrobe   (latchStrobe),
    .depthSel      (depthSel),
    .atLimit       (atLimit),
    .strobes       (strobes),
    .liveNibbles   (liveNibbles),
    .storedNibbles (storedNibbles)
  );

  pixcnt_datapath #(
    .NIBBLE_W    (NIBBLE_W),
    .NUM_NIBBLES (NUM_NIBBLES),
    .NIB_CNT_W   (NIB_CNT_W),
    .NIB_SEL_W   (NIB_SEL_W),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .liveNibbles   (liveNibbles),
    .storedNibbles (storedNibbles),
    .nibbleSel     (nibbleSel),
    .atLimit       (atLimit),
    .liveCnt       (liveCnt),
    .shadowCnt     (shadowCnt),
    .nibbleOut     (nibbleOut)
  );

endmodule

// File: rtl/pixcnt_checker.sv
module pixcnt_checker #(
  parameter int NIBBLE_W    = 4,
  parameter int NUM_NIBBLES = 3,
  parameter int NIB_SEL_W   = 2,
  parameter int CNT_W       = NIBBLE_W * NUM_NIBBLES
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hitIn,
  input logic                 countEn,
  input logic                 latchStrobe,
  input logic [NIB_SEL_W-1:0] nibbleSel,
  input logic [NIBBLE_W-1:0]  nibbleOut,
  input logic [CNT_W-1:0]     liveCnt,
  input logic [CNT_W-1:0]     shadowCnt
);

  // R1: no enabled hit, no change
  a_r1_hold_without_hit: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStrobe && !(countEn && hitIn)) |=> $stable(liveCnt));

  // R2: steps of at most one and never a wrap
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    !latchStrobe |=> ({1'b0, liveCnt} == {1'b0, $past(liveCnt)} ||
                      {1'b0, liveCnt} == {1'b0, $past(liveCnt)} + (CNT_W+1)'(1)));

  // R3: strobe moves the count into the shadow and clears it on the same edge
  a_r3_latch_transfer: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> (liveCnt == '0 && shadowCnt == $past(liveCnt)));

  // R4: shadow holds between strobes
  a_r4_shadow_stable: assert property (@(posedge clk) disable iff (!rstN)
    !latchStrobe |=> $stable(shadowCnt));

  // R6: low nibble always visible, unused select reads zero
  a_r6_low_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (nibbleSel == '0) |-> (nibbleOut == shadowCnt[NIBBLE_W-1:0]));

  a_r6_unused_select: assert property (@(posedge clk) disable iff (!rstN)
    (int'(nibbleSel) >= NUM_NIBBLES) |-> (nibbleOut == '0));

endmodule

bind pixcnt_top pixcnt_checker #(
  .NIBBLE_W    (NIBBLE_W),
  .NUM_NIBBLES (NUM_NIBBLES),
  .NIB_SEL_W   (NIB_SEL_W),
  .CNT_W       (CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hitIn       (hitIn),
  .countEn     (countEn),
  .latchStrobe (latchStrobe),
  .nibbleSel   (nibbleSel),
  .nibbleOut   (nibbleOut),
  .liveCnt     (liveCnt),
  .shadowCnt   (shadowCnt)
);

// File: tb/pixcnt_top_bench.sv
module pixcnt_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hitIn;
  logic       countEn;
  logic       latchStrobe;
  logic [1:0] depthSel;
  logic [1:0] nibbleSel;
  logic [3:0] nibbleOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pixcnt_top u_pixcnt_top (
    .clk         (clk),
    .rstN        (rstN),
    .hitIn       (hitIn),
    .countEn     (countEn),
    .latchStrobe (latchStrobe),
    .depthSel    (depthSel),
    .nibbleSel   (nibbleSel),
    .nibbleOut   (nibbleOut)
  );

  // Vector table: depth code, hits in the frame, enable, expected stored count.
  localparam int NVEC = 9;
  localparam int V_CODE [NVEC] = '{0,  0,   1,   1,    2,    2,  3,  2,  2};
  localparam int V_HITS [NVEC] = '{5, 20, 200, 300, 1000, 4100, 17, 50,  0};
  localparam int V_EN   [NVEC] = '{1,  1,   1,   1,    1,    1,  1,  0,  1};
  localparam int V_EXP  [NVEC] = '{5, 15, 200, 255, 1000, 4095, 17,  0,  0};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readNibble(input int s, output int v);
    @(negedge clk);
    nibbleSel = 2'(s);
    #1;
    v = int'(nibbleOut);
  endtask

  task automatic readStored(output int v);
    int n;
    v = 0;
    for (int s = 0; s < 3; s++) begin
      readNibble(s, n);
      v = v | (n << (4 * s));
    end
  endtask

  task automatic latchFrame(input logic [1:0] code);
    @(negedge clk);
    depthSel    = code;
    latchStrobe = 1'b1;
    hitIn       = 1'b0;
    @(negedge clk);
    latchStrobe = 1'b0;
  endtask

  task automatic hits(input int n, input logic en);
    countEn = en;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hitIn = 1'b1;
    end
    @(negedge clk);
    hitIn = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    rstN = 1'b0; hitIn = 1'b0; countEn = 1'b0; latchStrobe = 1'b0;
    depthSel = 2'd0; nibbleSel = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state
    readStored(v);
    check("R8 reset stored value", v, 0);

    // R5: reset depth is 12 bits, so 20 hits survive a code-0 latch request
    hits(20, 1'b1);
    latchFrame(2'd0);
    readStored(v);
    check("R5 reset depth 12 bits", v, 20);

    // R5: mid-frame change to 12 bits ignored, frame saturates at 15
    @(negedge clk); depthSel = 2'd2;
    hits(30, 1'b1);
    latchFrame(2'd2);
    readStored(v);
    check("R5 mid-frame depth change ignored", v, 15);
    readNibble(1, v);
    check("R7 nibble above 4-bit depth", v, 0);

    // R1/R2: vector table
    for (int i = 0; i < NVEC; i++) begin
      latchFrame(2'(V_CODE[i]));
      hits(V_HITS[i], V_EN[i] != 0);
      latchFrame(2'(V_CODE[i]));
      readStored(v);
      check($sformatf("R1/R2 vector %0d", i), v, V_EXP[i]);
    end

    // R3: hit on the strobe edge lost in both frames
    latchFrame(2'd2);
    hits(3, 1'b1);
    @(negedge clk);
    hitIn = 1'b1; latchStrobe = 1'b1; depthSel = 2'd2;
    @(negedge clk);
    hitIn = 1'b0; latchStrobe = 1'b0;
    readStored(v);
    check("R3 strobe captures prior count", v, 3);
    latchFrame(2'd2);
    readStored(v);
    check("R3 hit at strobe dropped", v, 0);

    // R4: shadow unchanged while the next frame counts
    hits(9, 1'b1);
    latchFrame(2'd2);
    hits(7, 1'b1);
    readStored(v);
    check("R4 shadow stable during counting", v, 9);
    latchFrame(2'd2);
    readStored(v);
    check("R4 next frame stored", v, 7);

    // R6: nibble ordering with 0xABC
    hits(2748, 1'b1);
    latchFrame(2'd2);
    readNibble(0, v); check("R6 nibble 0", v, 12);
    readNibble(1, v); check("R6 nibble 1", v, 11);
    readNibble(2, v); check("R6 nibble 2", v, 10);
    readNibble(3, v); check("R6 select 3 reads zero", v, 0);

    // R7: 8-bit frame, top nibble zero
    latchFrame(2'd1);
    hits(300, 1'b1);
    latchFrame(2'd1);
    readNibble(2, v); check("R7 nibble above 8-bit depth", v, 0);
    readNibble(1, v); check("R2 8-bit saturation high nibble", v, 15);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule